// File: doc/BRIEF.md
# Streaming Binary Dot-Product Engine

The engine scores one frequently changing input bit vector against up to `MAX_REFS` stored reference bit vectors. Each score is the binary dot product: the number of bit positions where both the input vector and that reference hold a 1. Both vectors are cut into `CHUNKS` words of `WORD_W` bits and arrive as one interleaved word stream. For every chunk position, the input vector's word for that position comes first. It is followed by the word at the same position of reference 0, reference 1, and so on up to reference `num_refs-1`.

The input word is held in a register. Each reference word that follows is ANDed with the held word and popcounted. The popcount is then added into that reference's running total. The totals sit in an on-chip accumulator RAM, and each update is a read-modify-write in a short pipeline that takes one word per clock. The first chunk of a vector overwrites the stored totals, so no clear sweep is needed between vectors. A flag reports when the last update of the vector has landed. The totals are then read back one per cycle through a read port. A read takes the RAM's read port for that cycle, and the stream is held off while it does.

Top module: `bitdot_engine`

## Requirements
- R1: After reset, `done` is 0, and `in_ready` is 1 whenever `rd_en` is 0.
- R2: `in_kind` = 0 marks an input-vector word. It is held, and the reference numbering for its chunk restarts at 0. `in_kind` = 1 marks a reference word, which goes to the next reference number (0, 1, 2, ...). The first input-vector word after reset, or after a completed vector, is chunk 0, and each later one is the next chunk.
- R3: After a full vector, the total of reference r equals the sum over all `CHUNKS` chunks of popcount(reference word AND input word). The total is `ACC_W` = ceil(log2(`WORD_W`*`CHUNKS`+1)) bits wide (21 at the defaults), so the full-scale count, every bit set, is held without overflow.
- R4: Chunk 0 overwrites each reference's total instead of adding to it, so no value from an earlier vector survives.
- R5: The following reference words are accepted and discarded without changing any total: reference words beyond `num_refs` within a chunk, and reference words that arrive before the first input-vector word of a vector.
- R6: `done` rises two rising edges after the final reference word of the last chunk is accepted, plus one edge for every cycle in that window in which `rd_en` is high. It stays high until the next word is accepted.
- R7: While `rd_en` is 1, `in_ready` is 0 and no word is accepted. The cycle after `rd_en`, `rd_data` carries the total stored at `rd_addr`.
- R8: One word is accepted on every cycle in which `in_valid` is 1 and `rd_en` is 0. Idle cycles in the stream do not change any total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| num_refs | input | NREF_W | Number of reference vectors, 1 to MAX_REFS, held constant during a vector |
| in_valid | input | 1 | Stream word present |
| in_kind | input | 1 | 0 = input-vector word, 1 = reference word |
| in_data | input | WORD_W | Stream word |
| in_ready | output | 1 | Engine takes the word this cycle |
| done | output | 1 | Last update of the vector has been written |
| rd_en | input | 1 | Read one accumulated total |
| rd_addr | input | ADDR_W | Reference number to read |
| rd_data | output | ACC_W | Total, valid the cycle after rd_en |

## Verification
The case hardest to reach from the ports is a read that arrives while a reference word sits between acceptance and its RAM read. In that case the pipeline must freeze that word, and the update must still land intact. The stimulus raises `rd_en` on the cycle right after a reference word is accepted, once in every chunk. Stray reference words are also placed before the vector's first input word and after each chunk's last reference, and idle gaps are mixed into the stream. The per-reference totals, checked against a behavioural model after each vector, then show whether any of these disturbed an accumulation.

// File: rtl/bitdot_pkg.sv
package bitdot_pkg;

   typedef enum logic {
      KIND_INPUT = 1'b0,
      KIND_REF   = 1'b1
   } word_kind_e;

endpackage

// File: rtl/bitdot_popcount.sv
module bitdot_popcount #(
   parameter int WORD_W = 32,
   parameter int GROUP  = 4
) (
   input  logic [WORD_W-1:0]            bits,
   output logic [$clog2(WORD_W+1)-1:0]  count
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam int GRP_W = $clog2(GROUP + 1);
   localparam int N_GRP = WORD_W / GROUP;

   logic [N_GRP*GRP_W-1:0] parts;

   generate
      if (GROUP < 1 || (WORD_W % GROUP) != 0) begin : g_bad_group
         $error("bitdot_popcount: GROUP must divide WORD_W");
      end
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         logic [GRP_W-1:0] grp_cnt;
         always_comb begin
            grp_cnt = '0;
            for (int b = 0; b < GROUP; b++) begin
               grp_cnt = grp_cnt + GRP_W'(bits[g*GROUP + b]);
            end
         end
         assign parts[g*GRP_W +: GRP_W] = grp_cnt;
      end
   endgenerate

   // second level: add the group counts
   always_comb begin
      count = '0;
      for (int g = 0; g < N_GRP; g++) begin
         count = count + CNT_W'(parts[g*GRP_W +: GRP_W]);
      end
   end

endmodule

// File: rtl/bitdot_acc_ram.sv
module bitdot_acc_ram #(
   parameter int DEPTH  = 1024,
   parameter int DATA_W = 21,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   // one write port, one registered read port; read returns the old word on a same-edge collision
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/bitdot_sequencer.sv
module bitdot_sequencer
   import bitdot_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int CHUNKS   = 32768,
   parameter int MAX_REFS = 1024,
   localparam int ADDR_W  = (MAX_REFS > 1) ? $clog2(MAX_REFS) : 1,
   localparam int NREF_W  = $clog2(MAX_REFS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              kind,
   input  logic [WORD_W-1:0] data,
   input  logic [NREF_W-1:0] num_refs,
   output logic              upd_valid,
   output logic [ADDR_W-1:0] upd_addr,
   output logic [WORD_W-1:0] upd_word,
   output logic              upd_first,
   output logic              upd_last
);
   localparam int CHUNK_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
   localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(CHUNKS - 1);

   logic [WORD_W-1:0]  held_word;
   logic               have_input;
   logic [CHUNK_W-1:0] chunk_idx;
   logic [NREF_W-1:0]  ref_idx;
   logic               is_ref;

   assign is_ref    = (word_kind_e'(kind) == KIND_REF);
   assign upd_valid = accept && is_ref && have_input && (ref_idx < num_refs);
   assign upd_addr  = ref_idx[ADDR_W-1:0];
   assign upd_word  = data & held_word;
   assign upd_first = (chunk_idx == '0);
   assign upd_last  = (chunk_idx == LAST_CHUNK) && (ref_idx == (num_refs - NREF_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_word  <= '0;
         have_input <= 1'b0;
         chunk_idx  <= '0;
         ref_idx    <= '0;
      end else if (accept && !is_ref) begin
         held_word  <= data;
         have_input <= 1'b1;
         ref_idx    <= '0;
         chunk_idx  <= have_input ? chunk_idx + CHUNK_W'(1) : '0;
      end else if (upd_valid) begin
         ref_idx <= ref_idx + NREF_W'(1);
         if (upd_last) begin
            have_input <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/bitdot_engine.sv
module bitdot_engine
   import bitdot_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CHUNKS    = 32768,
   parameter int MAX_REFS  = 1024,
   parameter int POP_GROUP = 4,
   localparam int ACC_W    = $clog2(WORD_W * CHUNKS + 1),
   localparam int ADDR_W   = (MAX_REFS > 1) ? $clog2(MAX_REFS) : 1,
   localparam int NREF_W   = $clog2(MAX_REFS + 1),
   localparam int POP_W    = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREF_W-1:0] num_refs,
   input  logic              in_valid,
   input  logic              in_kind,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              done,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [ACC_W-1:0]  rd_data
);
   generate
      if (WORD_W < 1 || CHUNKS < 1 || MAX_REFS < 1) begin : g_bad_size
         $error("bitdot_engine: WORD_W, CHUNKS and MAX_REFS must be positive");
      end
      if (ACC_W > 31) begin : g_bad_acc
         $error("bitdot_engine: accumulator wider than 31 bits");
      end
   endgenerate

   logic              accept;
   logic              advance;
   logic              upd_valid;
   logic [ADDR_W-1:0] upd_addr;
   logic [WORD_W-1:0] upd_word;
   logic              upd_first;
   logic              upd_last;

   // stage 1: masked word waiting for popcount and RAM read
   logic              s1_valid;
   logic [ADDR_W-1:0] s1_addr;
   logic [WORD_W-1:0] s1_word;
   logic              s1_first;
   logic              s1_last;
   logic [POP_W-1:0]  s1_pop;

   // stage 2: popcount ready, old total arriving from RAM
   logic              s2_valid;
   logic [ADDR_W-1:0] s2_addr;
   logic [POP_W-1:0]  s2_pop;
   logic              s2_first;
   logic              s2_last;

   logic              ram_re;
   logic [ADDR_W-1:0] ram_raddr;
   logic [ACC_W-1:0]  ram_q;
   logic              wr_en;
   logic [ACC_W-1:0]  wr_data;

   // a host read owns the RAM read port and freezes the front of the pipeline
   assign in_ready = !rd_en;
   assign advance  = !rd_en;
   assign accept   = in_valid && in_ready;

   bitdot_sequencer #(
      .WORD_W   (WORD_W),
      .CHUNKS   (CHUNKS),
      .MAX_REFS (MAX_REFS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .kind      (in_kind),
      .data      (in_data),
      .num_refs  (num_refs),
      .upd_valid (upd_valid),
      .upd_addr  (upd_addr),
      .upd_word  (upd_word),
      .upd_first (upd_first),
      .upd_last  (upd_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
         s1_word  <= '0;
         s1_first <= 1'b0;
         s1_last  <= 1'b0;
      end else if (advance) begin
         s1_valid <= upd_valid;
         s1_addr  <= upd_addr;
         s1_word  <= upd_word;
         s1_first <= upd_first;
         s1_last  <= upd_last;
      end
   end

   bitdot_popcount #(
      .WORD_W (WORD_W),
      .GROUP  (POP_GROUP)
   ) u_pop (
      .bits  (s1_word),
      .count (s1_pop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_addr  <= '0;
         s2_pop   <= '0;
         s2_first <= 1'b0;
         s2_last  <= 1'b0;
      end else begin
         s2_valid <= s1_valid && advance;
         s2_addr  <= s1_addr;
         s2_pop   <= s1_pop;
         s2_first <= s1_first;
         s2_last  <= s1_last;
      end
   end

   assign ram_re    = rd_en || (s1_valid && advance);
   assign ram_raddr = rd_en ? rd_addr : s1_addr;
   assign wr_en     = s2_valid;
   assign wr_data   = (s2_first ? '0 : ram_q) + ACC_W'(s2_pop);

   bitdot_acc_ram #(
      .DEPTH  (MAX_REFS),
      .DATA_W (ACC_W)
   ) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (s2_addr),
      .wdata (wr_data),
      .re    (ram_re),
      .raddr (ram_raddr),
      .rdata (ram_q)
   );

   assign rd_data = ram_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
      end else if (s2_valid && s2_last) begin
         done <= 1'b1;
      end else if (accept) begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/bitdot_checks.sv
module bitdot_checks #(
   parameter int ADDR_W  = 10,
   parameter int ACC_W   = 21,
   parameter int MAX_SUM = 1048576
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              rd_en,
   input logic              done,
   input logic              wr_en,
   input logic [ACC_W-1:0]  wr_data,
   input logic              s1_valid,
   input logic [ADDR_W-1:0] s1_addr
);

   a_r7_read_blocks_stream: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !in_ready);

   a_r7_stall_holds_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && rd_en) |=> (s1_valid && $stable(s1_addr)));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_data) <= MAX_SUM));

   a_r6_done_falls_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(in_valid && in_ready));

   a_r6_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wr_en));

endmodule

bind bitdot_engine bitdot_checks #(
   .ADDR_W  (ADDR_W),
   .ACC_W   (ACC_W),
   .MAX_SUM (WORD_W * CHUNKS)
) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .rd_en    (rd_en),
   .done     (done),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .s1_valid (s1_valid),
   .s1_addr  (s1_addr)
);

// File: tb/sim_bitdot_engine.sv
module sim_bitdot_engine;
   localparam int CLK_PERIOD = 10;
   localparam int T_W    = 32;
   localparam int T_CH   = 4;
   localparam int T_MR   = 8;
   localparam int T_ACC  = $clog2(T_W * T_CH + 1);
   localparam int T_ADDR = $clog2(T_MR);
   localparam int T_NREF = $clog2(T_MR + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [T_NREF-1:0] num_refs;
   logic              in_valid;
   logic              in_kind;
   logic [T_W-1:0]    in_data;
   logic              in_ready;
   logic              done;
   logic              rd_en;
   logic [T_ADDR-1:0] rd_addr;
   logic [T_ACC-1:0]  rd_data;

   bitdot_engine #(
      .WORD_W   (T_W),
      .CHUNKS   (T_CH),
      .MAX_REFS (T_MR)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .num_refs (num_refs),
      .in_valid (in_valid),
      .in_kind  (in_kind),
      .in_data  (in_data),
      .in_ready (in_ready),
      .done     (done),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural model of the stream meaning and the done timing
   int          macc [T_MR];
   int          m_chunk;
   int          m_ref;
   bit          m_have;
   logic [31:0] m_in;
   bit          st_a, st_b, exp_done;

   always @(posedge clk) begin
      bit set_now;
      int pop;
      if (!rst_n) begin
         m_have = 0; m_ref = 0; m_chunk = 0; m_in = '0;
         st_a = 0; st_b = 0; exp_done = 0;
      end else begin
         set_now = st_b;
         st_b = 0;
         if (st_a && !rd_en) begin
            st_b = 1;
            st_a = 0;
         end
         if (in_valid && !rd_en) begin
            exp_done = 0;
            if (in_kind == 1'b0) begin
               m_chunk = m_have ? m_chunk + 1 : 0;
               m_have  = 1;
               m_ref   = 0;
               m_in    = in_data;
            end else if (m_have && m_ref < int'(num_refs)) begin
               pop = $countones(in_data & m_in);
               macc[m_ref] = (m_chunk == 0) ? pop : macc[m_ref] + pop;
               if (m_chunk == T_CH - 1 && m_ref == int'(num_refs) - 1) begin
                  st_a   = 1;
                  m_have = 0;
               end
               m_ref++;
            end
         end
         if (set_now) exp_done = 1;
      end
   end

   // per-clock comparison of the handshake and completion flag
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         #(CLK_PERIOD/4);
         check(in_ready == !rd_en, "R7 in_ready vs rd_en", in_ready, !rd_en);
         check(done == exp_done, "R6 done timing", done, exp_done);
      end
   end

   function automatic logic [31:0] mix(input int s, input int a, input int b);
      logic [31:0] x;
      x = (32'(s + 7) * 32'h9E3779B9) ^ (32'(a + 1) * 32'h85EBCA6B) ^ (32'(b + 3) * 32'hC2B2AE35);
      return x ^ {x[15:0], x[31:16]};
   endfunction

   task automatic send(input bit k, input logic [31:0] d);
      in_valid = 1'b1;
      in_kind  = k;
      in_data  = d;
      @(negedge clk);
   endtask

   task automatic gap(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic stall(input int a);
      in_valid = 1'b0;
      rd_en    = 1'b1;
      rd_addr  = T_ADDR'(a);
      @(negedge clk);
      rd_en    = 1'b0;
   endtask

   task automatic read_chk(input int a, input int exp, input string tag);
      in_valid = 1'b0;
      rd_en    = 1'b1;
      rd_addr  = T_ADDR'(a);
      @(negedge clk);
      rd_en    = 1'b0;
      check(int'(rd_data) == exp, tag, rd_data, exp);
   endtask

   // fill: 0 = pseudo-random words, 1 = every bit set, 2 = reference words all zero
   task automatic run_vec(input int n, input int seed, input bit gaps, input bit extra,
                          input bit stalls, input int fill);
      num_refs = T_NREF'(n);
      for (int c = 0; c < T_CH; c++) begin
         send(1'b0, (fill == 1) ? '1 : mix(seed, c, 99));
         for (int r = 0; r < n; r++) begin
            send(1'b1, (fill == 1) ? '1 : (fill == 2) ? '0 : mix(seed, c, r));
            if (stalls && r == 0) stall(c);
            if (gaps && ((r + c) % 2 == 0)) gap(1 + (r % 3));
         end
         if (extra) send(1'b1, '1);
      end
      gap(3);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      in_valid = 1'b0; in_kind = 1'b0; in_data = '0;
      rd_en = 1'b0; rd_addr = '0; num_refs = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1 done after reset", done, 0);
      check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

      // R2 R3: three references, back-to-back words
      run_vec(3, 11, 0, 0, 0, 0);
      check(done == 1'b1, "R6 done held while idle", done, 1);
      for (int r = 0; r < 3; r++) read_chk(r, macc[r], "R2 R3 total per reference");

      // R3: full-scale count with every bit set, single reference
      run_vec(1, 0, 0, 0, 0, 1);
      read_chk(0, T_CH * T_W, "R3 full-scale count");

      // R5 R8: all references, stray word first, surplus words, idle gaps
      num_refs = T_NREF'(T_MR);
      send(1'b1, '1);
      run_vec(T_MR, 23, 1, 1, 0, 0);
      for (int r = 0; r < T_MR; r++) read_chk(r, macc[r], "R5 R8 total with strays and gaps");

      // R7: reads right behind an accepted reference word
      run_vec(2, 37, 0, 0, 1, 0);
      read_chk(0, macc[0], "R7 total after mid-stream reads");
      read_chk(1, macc[1], "R7 total after mid-stream reads");

      // R4: zero references after non-zero totals leave nothing behind
      run_vec(2, 41, 0, 0, 0, 2);
      read_chk(0, 0, "R4 chunk 0 overwrites");
      read_chk(1, 0, "R4 chunk 0 overwrites");

      gap(2);
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule